// File: doc/BRIEF.md
# Circular FIFO with Remembered Last Operation

This block is a single-clock first-in first-out buffer built on a circular storage array. A producer writes words through a push port and watches a full indication; a consumer takes words through a pop port and watches an empty indication. The read and write indices are exactly as wide as the storage address and carry no extra wrap bit. When the two indices meet, a one-bit record of the last operation decides what that means. If the last operation was a push, the buffer is full. If it was a pop, the buffer is empty.

A cycle that both pushes and pops leaves that record as it was. So a full buffer that trades one word for another stays full, and an empty buffer never turns full. The word width and the depth are parameters. The depth must be a power of two, and the block refuses to elaborate otherwise. Output data is registered: it appears the cycle after a pop is accepted and then holds until the next accepted pop.

Top module: `lastop_fifo`

## Requirements
- R1: After reset the block shows empty high, full low and an output word of zero.
- R2: Words leave in the order they entered. The output word changes only in the cycle after an accepted pop, and it holds its value in every other cycle.
- R3: After DEPTH accepted pushes with no pops (net of pops), full is high and empty is low. Full and empty are never high together.
- R4: When every stored word has been popped, empty goes high in the cycle after the last accepted pop.
- R5: A push while full, without a pop in the same cycle, is ignored. Full stays high, and the stored words are unchanged when they are drained later.
- R6: A pop while empty is ignored. Empty stays high, and the output word keeps its previous value.
- R7: A push together with a pop while full is accepted on both sides. The oldest word comes out, the new word is appended, and full stays high.
- R8: A push together with a pop while empty accepts only the push. Empty goes low in the next cycle, and the output word is unchanged.
- R9: A push together with a pop at a partial fill level leaves the fill level unchanged and keeps first-in first-out order.
- R10: Both indices wrap modulo DEPTH. Order and the full/empty indications stay correct across many wraps under mixed traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Push request |
| wdata | input | DATA_W | Word to store on an accepted push |
| full | output | 1 | Buffer holds DEPTH words |
| pop | input | 1 | Pop request |
| rdata | output | DATA_W | Registered word from the latest accepted pop |
| empty | output | 1 | Buffer holds no words |

## Verification
Filling to capacity and then pushing alone separates a correct full decision from one that overwrites or wraps to empty. Paired push and pop while full is the case that tells a preserved last-operation record apart from one that collapses the buffer to empty. Paired requests while empty, and at a partial fill level, show that only legal operations are accepted and that occupancy holds. A long stretch of random mixed traffic then takes both indices through many wraps, so ordering and the meeting-point decision are tested at every index position.

// File: rtl/lastop_fifo_pkg.sv
package lastop_fifo_pkg;
   typedef enum logic {
      OP_POP  = 1'b0,
      OP_PUSH = 1'b1
   } last_op_e;
endpackage

// File: rtl/lfifo_ptr.sv
module lfifo_ptr #(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);
   // Power-of-two depth lets the natural binary rollover do the modulo wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/lfifo_track.sv
module lfifo_track
   import lastop_fifo_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push_ok,
   input  logic pop_ok,
   input  logic ptrs_eq,
   output logic full,
   output logic empty
);
   last_op_e last_op;

   // A paired push and pop keeps the record, so a full buffer stays full.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  last_op <= OP_POP;
      else if (push_ok && !pop_ok) last_op <= OP_PUSH;
      else if (pop_ok && !push_ok) last_op <= OP_POP;
   end

   always_comb begin
      full  = ptrs_eq && (last_op == OP_PUSH);
      empty = ptrs_eq && (last_op == OP_POP);
   end
endmodule

// File: rtl/lfifo_store.sv
module lfifo_store #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 8,
   parameter bit RESET_STORE = 1'b0,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_STORE) begin : g_rst_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   // The registered read takes the old slot content even when the same slot is written.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/lastop_fifo.sv
module lastop_fifo #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 8,
   parameter bit RESET_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   output logic              full,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              empty
);
   localparam int ADDR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lastop_fifo: DEPTH must be a power of two and at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("lastop_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] wr_ptr;
   logic [ADDR_W-1:0] rd_ptr;
   logic              push_ok;
   logic              pop_ok;

   always_comb begin
      pop_ok  = pop && !empty;
      push_ok = push && (!full || pop_ok);
   end

   lfifo_ptr #(.ADDR_W(ADDR_W)) u_wr_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (push_ok),
      .ptr   (wr_ptr)
   );

   lfifo_ptr #(.ADDR_W(ADDR_W)) u_rd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (pop_ok),
      .ptr   (rd_ptr)
   );

   lfifo_track u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_ok (push_ok),
      .pop_ok  (pop_ok),
      .ptrs_eq (wr_ptr == rd_ptr),
      .full    (full),
      .empty   (empty)
   );

   lfifo_store #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .RESET_STORE (RESET_STORE)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_addr (wr_ptr),
      .wr_data (wdata),
      .rd_en   (pop_ok),
      .rd_addr (rd_ptr),
      .rd_data (rdata)
   );
endmodule

// File: rtl/lastop_fifo_chk.sv
module lastop_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push,
   input logic              pop,
   input logic              full,
   input logic              empty,
   input logic [DATA_W-1:0] rdata
);
   localparam int OCC_W = $clog2(DEPTH + 1);

   // Occupancy is tracked from the port requests only.
   logic [OCC_W-1:0] occ;
   logic             acc_pop;
   logic             acc_push;

   always_comb begin
      acc_pop  = pop && (occ != '0);
      acc_push = push && ((occ != OCC_W'(DEPTH)) || acc_pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + OCC_W'(acc_push) - OCC_W'(acc_pop);
   end

   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> (empty && !full && rdata == '0));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> ($stable(rdata) && $stable(full) && $stable(empty)));

   assert_never_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full == (occ == OCC_W'(DEPTH)));

   assert_empty_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (occ == '0));

   assert_full_push_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

   assert_empty_pop_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rdata)));

   assert_full_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop) |=> full);

   assert_empty_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && push && pop) |=> (!empty && $stable(rdata)));
endmodule

bind lastop_fifo lastop_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .push  (push),
   .pop   (pop),
   .full  (full),
   .empty (empty),
   .rdata (rdata)
);

// File: tb/lastop_fifo_bench.sv
module lastop_fifo_bench;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push = 1'b0;
   logic              pop = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic              full;
   logic              empty;
   logic [DATA_W-1:0] rdata;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string tag = "R1";

   logic [DATA_W-1:0] mq[$];
   logic [DATA_W-1:0] exp_rdata = '0;

   always #10 clk = ~clk;

   lastop_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lastop_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (wdata),
      .full  (full),
      .pop   (pop),
      .rdata (rdata),
      .empty (empty)
   );

   // Behavioural reference: a queue bounded at DEPTH.
   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         exp_rdata = '0;
      end else begin
         bit p_ok;
         bit w_ok;
         p_ok = pop && (mq.size() > 0);
         w_ok = push && ((mq.size() < DEPTH) || p_ok);
         if (p_ok) exp_rdata = mq.pop_front();
         if (w_ok) mq.push_back(wdata);
      end
   end

   task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // Compare every clock, half a period away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "full",  DATA_W'(full),  DATA_W'(mq.size() == DEPTH));
         check(tag, "empty", DATA_W'(empty), DATA_W'(mq.size() == 0));
         check(tag, "rdata", rdata, exp_rdata);
      end
   end

   task automatic report();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         report();
      end
   end

   task automatic step(input bit p, input bit q, input logic [DATA_W-1:0] d);
      @(posedge clk);
      #2;
      push  = p;
      pop   = q;
      wdata = d;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state seen at the ports
      check("R1", "empty after reset", DATA_W'(empty), 1);
      check("R1", "full after reset",  DATA_W'(full),  0);
      check("R1", "rdata after reset", rdata, '0);

      tag = "R3";
      for (int i = 0; i < DEPTH; i++) step(1, 0, DATA_W'(8'hA0 + i));
      tag = "R5";
      step(1, 0, 8'hEE);
      step(1, 0, 8'hEF);
      tag = "R7";
      step(1, 1, 8'hB0);
      step(1, 1, 8'hB1);
      step(1, 1, 8'hB2);
      tag = "R4";
      for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00);
      tag = "R2";
      step(0, 0, 8'h55);
      step(0, 0, 8'h56);
      tag = "R6";
      step(0, 1, 8'h00);
      step(0, 1, 8'h00);
      tag = "R8";
      step(1, 1, 8'hC0);
      step(0, 0, 8'h00);
      tag = "R9";
      step(1, 0, 8'hC1);
      for (int i = 0; i < 5; i++) step(1, 1, DATA_W'(8'hD0 + i));
      tag = "R10";
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 3);
         step(r[0], r[1], DATA_W'($urandom));
      end
      tag = "R2";
      for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 8'h00);
      step(0, 0, 8'h00);
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      report();
   end
endmodule